// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the register file that sits between a processor bus and a bank of DMA channel engines. Software programs each channel's transfer mode and direction through packed control words, turns each channel's interrupt on or off, and reads a status word that collects every channel's activity state together with its completion and error flags. The block drives mode and direction to each channel engine and raises a single interrupt line whenever any enabled channel has a pending flag.

Channels are split into two groups of eight. The low group (channels 0 to 7) is configured through the first control word and reported through the first status word. The high group (channels 8 and up) is configured through the fourth control word and reported through the third status word. In both places a channel's position is its index minus the group base. Software acknowledges a completion or an error by writing back a 1 in that flag's position. The status word it just read can be written back as it is. The channel data paths and the per-channel descriptor registers above the control area are not part of this block.

Top module: `dmareg_top`

## Requirements
- R1: After reset, every channel drives mode 0 and direction 0, the interrupt output is low, and every readable word is zero except for the live activity-state fields.
- R2: In the word at 0x00, channel c (0 to 7) owns bits 4c+1..4c as its mode and bit 4c+2 as its direction. A write sets `ch_mode`/`ch_dir` from those bits on the next cycle. Bit 4c+3 always reads 0.
- R3: In the word at 0x0C, channel c (8 to 11) owns the same 3-bit layout at bit 4(c-8). Bits 31:16 and every bit 4k+3 read 0.
- R4: In the word at 0x08, the interrupt enable of channel c sits at bit c for c below 8 and at bit c+8 for c of 8 and up. All other bits read 0.
- R5: The word at 0x10 shows, for channel c (0 to 7), its interrupt flag at bit c, its error flag at bit c+8, and its 2-bit `ch_state` input at bits 17+2c..16+2c. The word at 0x18 uses the same layout for channels 8 to 11 at index c-8. The state fields follow the input in the same cycle.
- R6: A `ch_done` pulse sets the channel's interrupt flag. A `ch_err` pulse sets both its interrupt and error flags. Flags stay set until they are cleared.
- R7: A write to 0x10 or 0x18 clears exactly those flags whose bit positions hold 1. Bits that hold 0 and bits in the state field have no effect.
- R8: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when some channel has its interrupt flag and its enable both set.
- R10: The word at 0x04 is a 32-bit read/write register. The words at 0x14 and 0x1C read 0. An address at 0x20 or above, or an address that is not word-aligned, reads 0, and a write to it changes nothing.
- R11: A write to one control word leaves the fields held in every other control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ch_done | input | 12 | Per-channel completion event pulse |
| ch_err | input | 12 | Per-channel error event pulse |
| ch_state | input | 24 | Per-channel 2-bit activity state, channel c at bits 2c+1..2c |
| ch_mode | output | 24 | Per-channel 2-bit mode, channel c at bits 2c+1..2c |
| ch_dir | output | 12 | Per-channel direction bit |
| irq | output | 1 | Combined interrupt |

## Verification
A flag can be set by a channel event and cleared by a bus write in the same clock. The bench provokes this by pulsing `ch_done` and `ch_err` in the same cycle as a write-one-to-clear aimed at those flags, and by clearing one channel's flag while a neighbouring channel raises its own. A behavioural model applies clears before sets, and the bench compares the status word, `irq` and every channel output with that model on every clock. The same comparison covers the other collision: a write to one control word while fields of the other group are held.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int WORD_W  = 32;
    localparam int GRP_CH  = 8;   // channels per control/status word
    localparam int FLD_W   = 4;   // control field stride
    localparam int STS_LSB = 16;  // first activity-state bit in a status word
    localparam int IDX_LSB = 2;
    localparam int IDX_W   = 3;

    typedef enum logic [IDX_W-1:0] {
        SEL_CTL0 = 3'd0,
        SEL_CTL1 = 3'd1,
        SEL_CTL2 = 3'd2,
        SEL_CTL3 = 3'd3,
        SEL_STS0 = 3'd4,
        SEL_STS1 = 3'd5,
        SEL_STS2 = 3'd6,
        SEL_RSVD = 3'd7
    } word_sel_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       dir;
    } chan_cfg_t;

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output word_sel_e         sel,
    output logic              hit,
    output logic              wr_ctl0,
    output logic              wr_ctl1,
    output logic              wr_ctl2,
    output logic              wr_ctl3,
    output logic              wr_sts0,
    output logic              wr_sts2
);

    localparam int REGION_LSB = IDX_LSB + IDX_W;

    always_comb begin
        hit     = (bus_addr[IDX_LSB-1:0] == '0) && ((bus_addr >> REGION_LSB) == '0);
        sel     = word_sel_e'(bus_addr[IDX_LSB +: IDX_W]);
        wr_ctl0 = 1'b0;
        wr_ctl1 = 1'b0;
        wr_ctl2 = 1'b0;
        wr_ctl3 = 1'b0;
        wr_sts0 = 1'b0;
        wr_sts2 = 1'b0;
        if (bus_we && hit) begin
            unique case (sel)
                SEL_CTL0: wr_ctl0 = 1'b1;
                SEL_CTL1: wr_ctl1 = 1'b1;
                SEL_CTL2: wr_ctl2 = 1'b1;
                SEL_CTL3: wr_ctl3 = 1'b1;
                SEL_STS0: wr_sts0 = 1'b1;
                SEL_STS2: wr_sts2 = 1'b1;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_we,
    input  chan_cfg_t cfg_wd,
    input  logic      en_we,
    input  logic      en_wd,
    input  logic      clr_we,
    input  logic      clr_irq,
    input  logic      clr_err,
    input  logic      ev_done,
    input  logic      ev_err,
    output chan_cfg_t cfg,
    output logic      en,
    output logic      irq_flag,
    output logic      err_flag
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            en  <= 1'b0;
        end else begin
            if (cfg_we) cfg <= cfg_wd;
            if (en_we)  en  <= en_wd;
        end
    end

    // a set from an event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            irq_flag <= ev_done | ev_err | (irq_flag & ~(clr_we & clr_irq));
            err_flag <= ev_err | (err_flag & ~(clr_we & clr_err));
        end
    end

endmodule

// File: rtl/dmareg_rdmux.sv
module dmareg_rdmux
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input  word_sel_e            sel,
    input  logic                 hit,
    input  logic [WORD_W-1:0]    ctl1,
    input  logic [2*NUM_CH-1:0]  mode,
    input  logic [NUM_CH-1:0]    dir,
    input  logic [NUM_CH-1:0]    en,
    input  logic [NUM_CH-1:0]    irq_f,
    input  logic [NUM_CH-1:0]    err_f,
    input  logic [2*NUM_CH-1:0]  state,
    output logic [WORD_W-1:0]    rdata
);

    logic [WORD_W-1:0] w_ctl0, w_ctl2, w_ctl3, w_sts0, w_sts2;

    always_comb begin
        w_ctl0 = '0;
        w_ctl2 = '0;
        w_ctl3 = '0;
        w_sts0 = '0;
        w_sts2 = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (c < GRP_CH) begin
                w_ctl0[FLD_W*(c%GRP_CH) +: 2]             = mode[2*c +: 2];
                w_ctl0[FLD_W*(c%GRP_CH) + 2]              = dir[c];
                w_ctl2[c]                                 = en[c];
                w_sts0[c%GRP_CH]                          = irq_f[c];
                w_sts0[(c%GRP_CH) + GRP_CH]               = err_f[c];
                w_sts0[STS_LSB + 2*(c%GRP_CH) +: 2]       = state[2*c +: 2];
            end else begin
                w_ctl3[FLD_W*(c%GRP_CH) +: 2]             = mode[2*c +: 2];
                w_ctl3[FLD_W*(c%GRP_CH) + 2]              = dir[c];
                w_ctl2[c + GRP_CH]                        = en[c];
                w_sts2[c%GRP_CH]                          = irq_f[c];
                w_sts2[(c%GRP_CH) + GRP_CH]               = err_f[c];
                w_sts2[STS_LSB + 2*(c%GRP_CH) +: 2]       = state[2*c +: 2];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            unique case (sel)
                SEL_CTL0: rdata = w_ctl0;
                SEL_CTL1: rdata = ctl1;
                SEL_CTL2: rdata = w_ctl2;
                SEL_CTL3: rdata = w_ctl3;
                SEL_STS0: rdata = w_sts0;
                SEL_STS2: rdata = w_sts2;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 12,   // 1 to 16
    parameter int ADDR_W = 8     // more than 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [NUM_CH-1:0]    ch_done,
    input  logic [NUM_CH-1:0]    ch_err,
    input  logic [2*NUM_CH-1:0]  ch_state,
    output logic [2*NUM_CH-1:0]  ch_mode,
    output logic [NUM_CH-1:0]    ch_dir,
    output logic                 irq
);

    word_sel_e          sel;
    logic               hit;
    logic               wr_ctl0, wr_ctl1, wr_ctl2, wr_ctl3, wr_sts0, wr_sts2;
    logic [WORD_W-1:0]  ctl1_q;
    logic [NUM_CH-1:0]  en_v;
    logic [NUM_CH-1:0]  irq_flag_v;
    logic [NUM_CH-1:0]  err_flag_v;

    dmareg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .sel      (sel),
        .hit      (hit),
        .wr_ctl0  (wr_ctl0),
        .wr_ctl1  (wr_ctl1),
        .wr_ctl2  (wr_ctl2),
        .wr_ctl3  (wr_ctl3),
        .wr_sts0  (wr_sts0),
        .wr_sts2  (wr_sts2)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       ctl1_q <= '0;
        else if (wr_ctl1) ctl1_q <= bus_wdata;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int SLOT  = c % GRP_CH;
        localparam int EN_B  = (c < GRP_CH) ? c : c + GRP_CH;
        localparam int F_LSB = FLD_W * SLOT;

        logic      cfg_we, clr_we;
        chan_cfg_t cfg_wd, cfg_q;

        if (c < GRP_CH) begin : g_lo
            assign cfg_we = wr_ctl0;
            assign clr_we = wr_sts0;
        end else begin : g_hi
            assign cfg_we = wr_ctl3;
            assign clr_we = wr_sts2;
        end

        assign cfg_wd.mode = bus_wdata[F_LSB +: 2];
        assign cfg_wd.dir  = bus_wdata[F_LSB + 2];

        dmareg_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we),
            .cfg_wd   (cfg_wd),
            .en_we    (wr_ctl2),
            .en_wd    (bus_wdata[EN_B]),
            .clr_we   (clr_we),
            .clr_irq  (bus_wdata[SLOT]),
            .clr_err  (bus_wdata[SLOT + GRP_CH]),
            .ev_done  (ch_done[c]),
            .ev_err   (ch_err[c]),
            .cfg      (cfg_q),
            .en       (en_v[c]),
            .irq_flag (irq_flag_v[c]),
            .err_flag (err_flag_v[c])
        );

        assign ch_mode[2*c +: 2] = cfg_q.mode;
        assign ch_dir[c]         = cfg_q.dir;
    end

    dmareg_rdmux #(.NUM_CH(NUM_CH)) u_rd (
        .sel   (sel),
        .hit   (hit),
        .ctl1  (ctl1_q),
        .mode  (ch_mode),
        .dir   (ch_dir),
        .en    (en_v),
        .irq_f (irq_flag_v),
        .err_f (err_flag_v),
        .state (ch_state),
        .rdata (bus_rdata)
    );

    assign irq = |(irq_flag_v & en_v);

endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk #(
    parameter int NUM_CH = 12,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [NUM_CH-1:0]   ch_done,
    input logic [NUM_CH-1:0]   ch_err,
    input logic [2*NUM_CH-1:0] ch_state,
    input logic [2*NUM_CH-1:0] ch_mode,
    input logic [NUM_CH-1:0]   ch_dir,
    input logic                irq,
    input logic [NUM_CH-1:0]   irq_flag,
    input logic [NUM_CH-1:0]   err_flag
);

    a_r6_event_sets_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ch_done | ch_err)) |=>
            ((irq_flag & $past(ch_done | ch_err)) == $past(ch_done | ch_err)));

    a_r6_err_sets_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_err) |=> ((err_flag & $past(ch_err)) == $past(ch_err)));

    a_r7_no_clear_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> (((irq_flag & $past(irq_flag)) == $past(irq_flag)) &&
                     ((err_flag & $past(err_flag)) == $past(err_flag))));

    a_r2_cfg_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(ch_mode) && $stable(ch_dir)));

    a_r9_irq_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(bus_we || (|(ch_done | ch_err))));

    if (NUM_CH >= 8) begin : g_live
        a_r5_state_live: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == ADDR_W'(16)) |-> (bus_rdata[31:16] == ch_state[15:0]));
    end

endmodule

bind dmareg_top dmareg_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ch_done   (ch_done),
    .ch_err    (ch_err),
    .ch_state  (ch_state),
    .ch_mode   (ch_mode),
    .ch_dir    (ch_dir),
    .irq       (irq),
    .irq_flag  (irq_flag_v),
    .err_flag  (err_flag_v)
);

// File: tb/tb_dmareg_top.sv
`timescale 1ns/1ps
module tb_dmareg_top;

    localparam int N = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  ch_done = '0;
    logic [N-1:0]  ch_err = '0;
    logic [2*N-1:0] ch_state = '0;
    logic [2*N-1:0] ch_mode;
    logic [N-1:0]  ch_dir;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model state
    int          m_mode [N];
    int          m_dir  [N];
    int          m_en   [N];
    int          m_irq  [N];
    int          m_err  [N];
    logic [31:0] m_ctl1;

    always #5 clk = ~clk;

    dmareg_top dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_done(ch_done),
        .ch_err(ch_err), .ch_state(ch_state), .ch_mode(ch_mode),
        .ch_dir(ch_dir), .irq(irq)
    );

    function automatic logic [31:0] exp_rdata(input logic [7:0] a);
        logic [31:0] r = 0;
        int g;
        if (a[1:0] != 0 || a >= 8'h20) return 0;
        for (int c = 0; c < N; c++) begin
            g = (c < 8) ? 0 : 1;
            case (a)
                8'h00: if (g == 0) r |= (m_mode[c] << (4*c)) | (m_dir[c] << (4*c + 2));
                8'h0C: if (g == 1) r |= (m_mode[c] << (4*(c-8))) | (m_dir[c] << (4*(c-8) + 2));
                8'h08: r |= m_en[c] << ((c < 8) ? c : c + 8);
                8'h10: if (g == 0) r |= (m_irq[c] << c) | (m_err[c] << (c + 8))
                                    | (int'(ch_state[2*c +: 2]) << (16 + 2*c));
                8'h18: if (g == 1) r |= (m_irq[c] << (c-8)) | (m_err[c] << c)
                                    | (int'(ch_state[2*c +: 2]) << (16 + 2*(c-8)));
                default: ;
            endcase
        end
        if (a == 8'h04) r = m_ctl1;
        return r;
    endfunction

    function automatic logic exp_irq();
        for (int c = 0; c < N; c++) if (m_irq[c] != 0 && m_en[c] != 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_clock();
        int g;
        for (int c = 0; c < N; c++) begin
            g = (c < 8) ? 0 : 1;
            if (bus_we) begin
                if (bus_addr == 8'h00 && g == 0) begin
                    m_mode[c] = int'(bus_wdata[4*c +: 2]); m_dir[c] = int'(bus_wdata[4*c + 2]);
                end
                if (bus_addr == 8'h0C && g == 1) begin
                    m_mode[c] = int'(bus_wdata[4*(c-8) +: 2]); m_dir[c] = int'(bus_wdata[4*(c-8) + 2]);
                end
                if (bus_addr == 8'h08) m_en[c] = int'(bus_wdata[(c < 8) ? c : c + 8]);
                if ((bus_addr == 8'h10 && g == 0) || (bus_addr == 8'h18 && g == 1)) begin
                    if (bus_wdata[c % 8])     m_irq[c] = 0;
                    if (bus_wdata[c % 8 + 8]) m_err[c] = 0;
                end
            end
            if (ch_done[c]) m_irq[c] = 1;
            if (ch_err[c]) begin m_irq[c] = 1; m_err[c] = 1; end
        end
        if (bus_we && bus_addr == 8'h04) m_ctl1 = bus_wdata;
    endtask

    task automatic compare(input string req);
        logic [31:0] er = exp_rdata(bus_addr);
        logic [2*N-1:0] em;
        logic [N-1:0] ed;
        bit bad = 0;
        for (int c = 0; c < N; c++) begin
            em[2*c +: 2] = m_mode[c][1:0];
            ed[c] = m_dir[c][0];
        end
        n_cmp++;
        if (bus_rdata !== er) begin
            bad = 1;
            $display("FAIL %s addr %h rdata actual %h expected %h", req, bus_addr, bus_rdata, er);
        end
        if (irq !== exp_irq()) begin
            bad = 1;
            $display("FAIL %s irq actual %b expected %b", req, irq, exp_irq());
        end
        if (ch_mode !== em || ch_dir !== ed) begin
            bad = 1;
            $display("FAIL %s mode/dir actual %h/%h expected %h/%h", req, ch_mode, ch_dir, em, ed);
        end
        if (bad) n_bad++;
    endtask

    // drive at negedge, compare mid-cycle, let the edge pass, advance model
    task automatic step(input string req, input logic we, input logic [7:0] a,
                        input logic [31:0] wd, input logic [N-1:0] dn, input logic [N-1:0] er);
        bus_we = we; bus_addr = a; bus_wdata = wd; ch_done = dn; ch_err = er;
        #1;
        compare(req);
        @(posedge clk);
        model_clock();
        @(negedge clk);
    endtask

    task automatic rd(input string req, input logic [7:0] a);
        step(req, 1'b0, a, 32'h0, '0, '0);
    endtask

    task automatic wr(input string req, input logic [7:0] a, input logic [31:0] d);
        step(req, 1'b1, a, d, '0, '0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < N; c++) begin
            m_mode[c] = 0; m_dir[c] = 0; m_en[c] = 0; m_irq[c] = 0; m_err[c] = 0;
        end
        m_ctl1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every word
        for (int a = 0; a < 9; a++) rd("R1", 8'(4*a));

        // R5: live activity-state fields
        ch_state = 24'hA5C36F;
        rd("R5", 8'h10);
        rd("R5", 8'h18);
        ch_state = 24'h3C0F96;
        rd("R5", 8'h18);

        // R2: low-group control fields
        wr("R2", 8'h00, 32'h9B6E_D4A7);
        rd("R2", 8'h00);
        rd("R2", 8'h0C);
        // R3: high-group control fields
        wr("R3", 8'h0C, 32'hFFFF_FFFF);
        rd("R3", 8'h0C);
        // R11: words are independent
        rd("R11", 8'h00);
        wr("R11", 8'h00, 32'h0000_0000);
        rd("R11", 8'h0C);
        wr("R11", 8'h0C, 32'h0000_0516);
        rd("R11", 8'h00);

        // R4: enable positions
        wr("R4", 8'h08, 32'hFFFF_FFFF);
        rd("R4", 8'h08);
        wr("R4", 8'h08, 32'h0004_0009);
        rd("R4", 8'h08);

        // R6: events set flags
        step("R6", 1'b0, 8'h10, 32'h0, 12'h008, 12'h000);
        rd("R6", 8'h10);
        step("R6", 1'b0, 8'h18, 32'h0, 12'h000, 12'h400);
        rd("R6", 8'h18);
        step("R6", 1'b0, 8'h10, 32'h0, 12'h001, 12'h020);
        rd("R6", 8'h10);
        rd("R9", 8'h08);

        // R7: write-one-to-clear
        wr("R7", 8'h10, 32'h0000_0000);
        rd("R7", 8'h10);
        wr("R7", 8'h10, 32'hFFFF_0000);
        rd("R7", 8'h10);
        wr("R7", 8'h10, 32'h0000_0008);
        rd("R7", 8'h10);
        wr("R7", 8'h18, 32'h0000_0400);
        rd("R7", 8'h18);

        // R8: set and clear in the same cycle
        step("R8", 1'b1, 8'h10, 32'h0000_2121, 12'h001, 12'h020);
        rd("R8", 8'h10);
        step("R8", 1'b1, 8'h18, 32'h0000_0404, 12'h800, 12'h000);
        rd("R8", 8'h18);

        // R9: combined interrupt vs enables
        wr("R9", 8'h08, 32'h0000_0000);
        rd("R9", 8'h10);
        wr("R9", 8'h08, 32'h0008_0000);
        rd("R9", 8'h18);
        wr("R9", 8'h18, 32'h0000_0008);
        rd("R9", 8'h18);
        wr("R9", 8'h08, 32'h0000_0001);
        wr("R9", 8'h10, 32'h0000_FFFF);
        rd("R9", 8'h10);

        // R10: placeholder, reserved and unmapped addresses
        wr("R10", 8'h04, 32'hDEAD_BEEF);
        rd("R10", 8'h04);
        wr("R10", 8'h14, 32'hFFFF_FFFF);
        rd("R10", 8'h14);
        wr("R10", 8'h1C, 32'hFFFF_FFFF);
        rd("R10", 8'h1C);
        wr("R10", 8'h20, 32'hFFFF_FFFF);
        wr("R10", 8'h40, 32'hFFFF_FFFF);
        wr("R10", 8'h01, 32'hFFFF_FFFF);
        rd("R10", 8'h00);
        rd("R10", 8'h08);
        rd("R10", 8'h20);
        rd("R10", 8'h04);

        finished = 1;
        summary();
    end

    initial begin
        #200000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

endmodule